// File: doc/BRIEF.md
# HDLC Receive Deframer and Bit Destuffer

The block takes a serial receive stream, one bit per cycle in which `bit_vld_i` is high. It follows the run of consecutive 1 bits on the line. From that run it tells apart four kinds of bit: flag bits, abort runs, stuffed zeros and content bits. It drops every stuffed zero and packs the remaining content into bytes, least significant bit first. Each byte appears on a byte strobe. The first byte of a frame carries a start marker. Every frame ends with an end-of-frame pulse, which carries an error bit, or with an abort pulse.

The deframer does not open a frame on every flag. After a flag it arms, and a frame opens only when real content follows. Flag fill between frames therefore produces no output. A flag followed by an abort run or by an idle line also produces no output. One flag can close a frame and arm the next frame. The deframer holds the most recent seven content bits back, so the leading bits of a closing flag are never packed into the byte stream. Address filtering, FCS checking and storage are done by the logic downstream.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, all output strobes (`byte_vld_o`, `sof_o`, `eof_o`, `err_o`, `abort_o`) and `line_idle_o` are low.
- R2: A flag is the pattern 0,1,1,1,1,1,1,0 (a 0, six 1s, then a 0). A run of back-to-back flags produces no byte, eof or abort output.
- R3: A flag followed by seven or more 1 bits opens no frame and produces no output.
- R4: `line_idle_o` goes high once fifteen consecutive valid 1 bits have been received. It goes low after the next valid 0 bit.
- R5: Inside a frame, a 0 bit that follows five consecutive 1 bits is removed and is not part of the byte data.
- R6: Content bytes are assembled least significant bit first. Each byte is shown for one cycle on `byte_o` with `byte_vld_o` high. `sof_o` is high together with the first byte of each frame.
- R7: A flag that closes a frame made of whole bytes gives one `eof_o` pulse with `err_o` low. The same flag arms the receiver for the next frame.
- R8: A frame whose content at the closing flag is not a whole number of bytes gives `eof_o` with `err_o` high. The partial bits are discarded.
- R9: Seven consecutive 1 bits inside an open frame give one `abort_o` pulse and no `eof_o`. The receiver then ignores everything until the next flag.
- R10: Cycles in which `bit_vld_i` is low have no effect, whatever the value on `bit_i`.
- R11: Only one of `byte_vld_o`, `eof_o` and `abort_o` is high in any cycle. Each output event follows the accepted bit that caused it by exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received line bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` for this cycle |
| byte_o | output | 8 | Assembled content byte |
| byte_vld_o | output | 1 | `byte_o` is valid this cycle |
| sof_o | output | 1 | Byte on `byte_o` is the first of a frame |
| eof_o | output | 1 | Frame closed by a flag |
| err_o | output | 1 | With `eof_o`: content was not whole bytes |
| abort_o | output | 1 | Open frame terminated by an abort run |
| line_idle_o | output | 1 | Fifteen or more consecutive 1 bits seen |

## Verification
Two things happen on the same received bit: the closing flag emits the end of one frame and also arms the deframer for the next one. The bench sends frames back to back with a single shared flag between them. It passes only if each frame's eof is followed by the next frame's start-marked first byte, with no lost or extra byte. The second collision is an abort that arrives while the last byte is still partly assembled. The bench expects the abort pulse with that byte dropped. All events are gathered from the ports and compared, in order, with a list that the bench builds from the frames it transmitted.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W    = 8;
  localparam int FLAG_RUN  = 6;  // ones inside a flag
  localparam int HOLD_BITS = BYTE_W - 1;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_ARMED,
    ST_FRAME
  } rx_state_e;

  typedef enum logic [1:0] {
    BC_DATA,
    BC_STUFF,
    BC_FLAG,
    BC_ABORT
  } bit_class_e;
endpackage

// File: rtl/hdlc_run_classify.sv
module hdlc_run_classify
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_RUN = 15,
  localparam int RUN_W = $clog2(IDLE_RUN + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       vld_i,
  output bit_class_e cls_o,
  output logic       line_idle_o
);
  logic [RUN_W-1:0] ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_q <= '0;
    else if (vld_i) begin
      if (!bit_i) ones_q <= '0;
      else if (ones_q != RUN_W'(IDLE_RUN)) ones_q <= ones_q + 1'b1;
    end
  end

  always_comb begin
    if (bit_i) cls_o = (ones_q >= RUN_W'(FLAG_RUN)) ? BC_ABORT : BC_DATA;
    else if (ones_q == RUN_W'(FLAG_RUN - 1)) cls_o = BC_STUFF;
    else if (ones_q == RUN_W'(FLAG_RUN)) cls_o = BC_FLAG;
    else cls_o = BC_DATA;
  end

  assign line_idle_o = (ones_q == RUN_W'(IDLE_RUN));

  assert_idle_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !bit_i) |=> !line_idle_o);
  assert_idle_needs_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_idle_o) |-> $past(vld_i && bit_i));
endmodule

// File: rtl/hdlc_bit_delay.sv
module hdlc_bit_delay #(
  parameter int DEPTH = 7,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic bit_i,
  input  logic flush_i,
  output logic out_vld_o,
  output logic out_bit_o
);
  logic [DEPTH-1:0] dq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign out_vld_o = push_i && full;
  assign out_bit_o = dq_q[DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      dq_q <= {dq_q[DEPTH-2:0], bit_i};
      if (!full) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !out_vld_o);
endmodule

// File: rtl/hdlc_byte_pack.sv
module hdlc_byte_pack #(
  parameter int W = 8,
  localparam int CNT_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  input  logic         clr_i,
  output logic         byte_vld_o,
  output logic [W-1:0] byte_o,
  output logic         partial_o
);
  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  assign byte_vld_o = bit_vld_i && (cnt_q == CNT_W'(W - 1));
  assign byte_o     = {bit_i, sh_q[W-1:1]};  // first bit lands in bit 0
  assign partial_o  = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (bit_vld_i) begin
      sh_q  <= {bit_i, sh_q[W-1:1]};
      cnt_q <= byte_vld_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_RUN = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              err_o,
  output logic              abort_o,
  output logic              line_idle_o
);
  bit_class_e        cls;
  rx_state_e         state_q, state_d;
  logic              first_q, first_d;
  logic              is_flag, is_abort, is_data, push, dl_vld, dl_bit;
  logic              pk_vld, pk_partial, flush;
  logic [BYTE_W-1:0] pk_byte;

  hdlc_run_classify #(.IDLE_RUN(IDLE_RUN)) u_classify (
    .clk_i, .rst_ni, .bit_i, .vld_i(bit_vld_i), .cls_o(cls), .line_idle_o
  );

  assign is_flag  = bit_vld_i && (cls == BC_FLAG);
  assign is_abort = bit_vld_i && (cls == BC_ABORT);
  assign is_data  = bit_vld_i && (cls == BC_DATA);
  assign push     = is_data && (state_q != ST_HUNT);
  assign flush    = is_flag || is_abort;

  // holds back the bits that turn out to be the head of a closing flag
  hdlc_bit_delay #(.DEPTH(HOLD_BITS)) u_delay (
    .clk_i, .rst_ni, .push_i(push), .bit_i, .flush_i(flush),
    .out_vld_o(dl_vld), .out_bit_o(dl_bit)
  );

  hdlc_byte_pack #(.W(BYTE_W)) u_pack (
    .clk_i, .rst_ni, .bit_vld_i(dl_vld), .bit_i(dl_bit), .clr_i(flush),
    .byte_vld_o(pk_vld), .byte_o(pk_byte), .partial_o(pk_partial)
  );

  always_comb begin
    state_d = state_q;
    first_d = first_q;
    if (is_flag) state_d = ST_ARMED;
    else if (is_abort) state_d = ST_HUNT;
    else if (dl_vld && state_q == ST_ARMED) begin
      state_d = ST_FRAME;
      first_d = 1'b1;
    end
    if (pk_vld) first_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      first_q    <= 1'b0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      sof_o      <= 1'b0;
      eof_o      <= 1'b0;
      err_o      <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      state_q    <= state_d;
      first_q    <= first_d;
      byte_vld_o <= pk_vld;
      sof_o      <= pk_vld && (first_q || state_q == ST_ARMED);
      if (pk_vld) byte_o <= pk_byte;
      eof_o      <= is_flag && (state_q == ST_FRAME);
      err_o      <= is_flag && (state_q == ST_FRAME) && pk_partial;
      abort_o    <= is_abort && (state_q == ST_FRAME);
    end
  end

  assert_single_event_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_vld_o, eof_o, abort_o}));
  assert_sof_on_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> byte_vld_o);
  assert_err_on_eof_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> eof_o);
  assert_quiet_without_vld_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> !(byte_vld_o || eof_o || abort_o));
  assert_eof_rearms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> state_q == ST_ARMED);
  assert_abort_hunts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> state_q == ST_HUNT);
endmodule

// File: tb/hdlc_rx_deframer_bench.sv
module hdlc_rx_deframer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic [7:0] byte_o;
  logic       byte_vld_o, sof_o, eof_o, err_o, abort_o, line_idle_o;

  int errors = 0;
  int checks = 0;
  int tx_ones = 0;
  int exp_q[$];
  int got_q[$];
  logic [7:0] fbuf [16];

  always #5 clk_i = ~clk_i;

  hdlc_rx_deframer u_hdlc_rx_deframer (
    .clk_i, .rst_ni, .bit_i, .bit_vld_i, .byte_o, .byte_vld_o, .sof_o,
    .eof_o, .err_o, .abort_o, .line_idle_o
  );

  // event codes: 1 byte, 2 byte+sof, 3 eof ok, 4 eof err, 5 abort
  function automatic int ev(int t, int d);
    return (t << 8) | d;
  endfunction

  always @(negedge clk_i) if (rst_ni) begin
    if (byte_vld_o) got_q.push_back(ev(sof_o ? 2 : 1, int'(byte_o)));
    if (eof_o) got_q.push_back(ev(err_o ? 4 : 3, 0));
    if (abort_o) got_q.push_back(ev(5, 0));
  end

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk_i);
    bit_i = b;
    bit_vld_i = 1'b1;
    @(negedge clk_i);
    bit_vld_i = 1'b0;
    repeat ($urandom % 3) begin
      bit_i = 1'($urandom);
      @(negedge clk_i);
    end
  endtask

  task automatic send_stuffed(logic b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        send_bit(1'b0);
        tx_ones = 0;
      end
    end else tx_ones = 0;
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    repeat (6) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_ones(int n);
    repeat (n) send_bit(1'b1);
  endtask

  // kind: 0 whole bytes, 1 trailing partial bits, 2 aborted
  task automatic send_frame(int nb, int extra, int kind);
    for (int i = 0; i < nb; i++) begin
      if (kind != 2 || i < nb - 1) exp_q.push_back(ev(i == 0 ? 2 : 1, int'(fbuf[i])));
      for (int j = 0; j < 8; j++) send_stuffed(fbuf[i][j]);
    end
    if (kind == 1) for (int j = 0; j < extra; j++) send_stuffed(1'($urandom));
    if (kind == 2) begin
      send_ones(8);
      exp_q.push_back(ev(5, 0));
    end else exp_q.push_back(ev(kind == 1 ? 4 : 3, 0));
    send_flag();
  endtask

  function automatic string req_of(int e);
    case (e >> 8)
      1, 2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic drain(string tag);
    repeat (4) @(negedge clk_i);
    check(got_q.size() == exp_q.size(), {tag, " event count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], {tag, "/", req_of(exp_q[i])}, got_q[i], exp_q[i]);
    exp_q.delete();
    got_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1917));
    repeat (3) @(negedge clk_i);
    check({byte_vld_o, sof_o, eof_o, err_o, abort_o, line_idle_o} == 6'b0, "R1 in reset",
          int'({byte_vld_o, sof_o, eof_o, err_o, abort_o, line_idle_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check({byte_vld_o, sof_o, eof_o, err_o, abort_o, line_idle_o} == 6'b0, "R1 after reset",
          int'({byte_vld_o, sof_o, eof_o, err_o, abort_o, line_idle_o}), 0);

    // R2: flag fill only
    repeat (6) send_flag();
    drain("R2");

    // R3: flag then a run of ones; R4: idle sets and clears
    send_ones(10);
    drain("R3");
    check(line_idle_o == 1'b0, "R4 below idle run", int'(line_idle_o), 0);
    send_ones(5);
    check(line_idle_o == 1'b1, "R4 idle at 15", int'(line_idle_o), 1);
    send_ones(3);
    check(line_idle_o == 1'b1, "R4 idle held", int'(line_idle_o), 1);
    send_bit(1'b0);
    check(line_idle_o == 1'b0, "R4 idle cleared", int'(line_idle_o), 0);
    send_flag();

    // R5: ones-heavy content forces stuffing
    fbuf[0] = 8'hFF; fbuf[1] = 8'h7E; fbuf[2] = 8'h3E; fbuf[3] = 8'hF8; fbuf[4] = 8'hFC;
    send_frame(5, 0, 0);
    drain("R5");

    // R7: frames sharing one flag
    fbuf[0] = 8'hA5; fbuf[1] = 8'h01;
    send_frame(2, 0, 0);
    fbuf[0] = 8'h80;
    send_frame(1, 0, 0);
    drain("R7");

    // R8: partial tails, including a frame with no whole byte
    fbuf[0] = 8'h12; fbuf[1] = 8'h34;
    send_frame(2, 3, 1);
    send_frame(0, 5, 1);
    drain("R8");

    // R9: abort inside a frame, then hunt and recover
    fbuf[0] = 8'h55; fbuf[1] = 8'hC3; fbuf[2] = 8'h0F;
    send_frame(3, 0, 2);
    fbuf[0] = 8'h9A;
    send_frame(1, 0, 2);
    fbuf[0] = 8'h66;
    send_frame(1, 0, 0);
    drain("R9");

    // R10: random frames, garbage on bit_i while bit_vld_i is low
    for (int f = 0; f < 40; f++) begin
      int kind = int'($urandom % 3);
      int nb = 1 + int'($urandom % 6);
      for (int i = 0; i < 16; i++) fbuf[i] = 8'($urandom);
      if ($urandom % 3 == 0) send_flag();
      send_frame(kind == 1 ? nb - 1 : nb, 1 + int'($urandom % 7), kind);
    end
    drain("R10");
    check(!byte_vld_o && !eof_o && !abort_o, "R11 quiet when idle",
          int'({byte_vld_o, eof_o, abort_o}), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule